// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block is a multi-cycle radix-2 integer divider. It sits beside an execution pipeline and takes two register values and a four-bit operation code. It returns either a quotient or a remainder. It covers 32-bit word and 64-bit doubleword operands, signed and unsigned arithmetic, and an extended-dividend form, in which the first operand becomes the upper half of a dividend twice as wide. It produces one quotient bit per clock cycle. A zero divisor, and the most negative signed value divided by minus one, are recognised before any iteration starts and finish after a single cycle.

A divide updates three overflow flags. These are a per-operation overflow, its 32-bit companion, and a summary bit that stays set once it has been set. A remainder operation leaves all three flags untouched. Every overflow case returns a result of zero. Condition recording and instruction decode belong to the surrounding pipeline.

Top module: `idiv_unit`

## Requirements
- R1: `op_i` bit 0 selects doubleword (1) or word (0), bit 1 signed, bit 2 extended, bit 3 remainder. Word operations read only bits 31:0 of `ra_i` and `rb_i`, and they return their result in bits 31:0 with bits 63:32 zero.
- R2: An unsigned divide returns the truncated quotient of the dividend by the divisor.
- R3: A signed divide truncates toward zero.
- R4: A remainder operation (bit 3 set) returns the remainder, which carries the sign of the dividend. The extended bit is ignored, and OV, OV32 and SO keep their values.
- R5: An extended divide uses a dividend of `ra` (or its low word) followed by 64 (or 32) zero bits, and a divisor of the same width.
- R6: A zero divisor gives a result of 0. On a divide it sets OV, OV32 and SO.
- R7: A signed operation whose dividend is the most negative value and whose divisor is minus one gives a result of 0. On a divide it sets OV, OV32 and SO.
- R8: An extended divide whose quotient does not fit the result width (signed or unsigned) gives a result of 0 and sets OV, OV32 and SO.
- R9: Counted from the rising edge that samples `start_i`, `done_o` is high after N+1 edges. N is 32 for a word divide or remainder, 64 for a doubleword or word-extended operation, and 128 for a doubleword-extended operation. The cases of R6 and R7 take 1 edge.
- R10: `done_o` is high for exactly one cycle. `result_o` holds its value until the next completion.
- R11: SO stays set until reset. A divide without overflow clears OV and OV32.
- R12: A `start_i` that arrives while an operation is running is ignored. A start in the cycle where `done_o` is high is accepted.
- R13: After reset, `result_o`, `done_o`, OV, OV32 and SO are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_i | input | 4 | {rem, ext, signed, dword} |
| ra_i | input | 64 | Dividend operand |
| rb_i | input | 64 | Divisor operand |
| result_o | output | 64 | Quotient or remainder |
| done_o | output | 1 | One-cycle completion strobe |
| ov_o | output | 1 | Overflow of the last divide |
| ov32_o | output | 1 | 32-bit overflow of the last divide |
| so_o | output | 1 | Sticky summary overflow |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. The bench provokes this by driving `start_i` high in the very cycle it sees `done_o`, with every back-to-back run, including one-cycle zero-divisor runs. In the cycle after such a start, the bench requires `done_o` low and `result_o` still equal to the previous result. It then requires the new operation to finish after its own full latency with its own value. A stray start pulse in the middle of a long run is also judged: the run must finish with the first operation's result and timing.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef struct packed {
    logic rem_op;
    logic ext;
    logic sgn;
    logic dw;
  } idiv_op_t;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
  import idiv_pkg::*;
#(
  parameter int XLEN  = 64,
  localparam int HALF  = XLEN / 2,
  localparam int DW    = 2 * XLEN,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  idiv_op_t          op_i,
  input  logic [XLEN-1:0]   ra_i,
  input  logic [XLEN-1:0]   rb_i,
  output logic [DW-1:0]     dvd_o,
  output logic [XLEN-1:0]   dsr_o,
  output logic [CNT_W-1:0]  iters_o,
  output logic              neg_a_o,
  output logic              neg_b_o,
  output logic              early_o
);
  logic [XLEN-1:0] a_w, b_w, a_neg, b_neg, a_mag, min_w, ones_w;
  logic [CNT_W-1:0] base;
  logic ext_eff;

  always_comb begin
    a_w    = op_i.dw ? ra_i : {{HALF{1'b0}}, ra_i[HALF-1:0]};
    b_w    = op_i.dw ? rb_i : {{HALF{1'b0}}, rb_i[HALF-1:0]};
    neg_a_o = op_i.sgn & (op_i.dw ? ra_i[XLEN-1] : ra_i[HALF-1]);
    neg_b_o = op_i.sgn & (op_i.dw ? rb_i[XLEN-1] : rb_i[HALF-1]);
    a_neg  = '0 - a_w;
    b_neg  = '0 - b_w;
    a_mag  = neg_a_o ? (op_i.dw ? a_neg : {{HALF{1'b0}}, a_neg[HALF-1:0]}) : a_w;
    dsr_o  = neg_b_o ? (op_i.dw ? b_neg : {{HALF{1'b0}}, b_neg[HALF-1:0]}) : b_w;
    // dividend left-aligned so that every mode shifts out its top bits first
    dvd_o  = op_i.dw ? {a_mag, {XLEN{1'b0}}} : {a_mag[HALF-1:0], {(DW-HALF){1'b0}}};
    min_w  = op_i.dw ? {1'b1, {(XLEN-1){1'b0}}} : {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}};
    ones_w = op_i.dw ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    early_o = (b_w == '0) | (op_i.sgn & (a_w == min_w) & (b_w == ones_w));
    ext_eff = op_i.ext & ~op_i.rem_op;
    base    = op_i.dw ? CNT_W'(XLEN) : CNT_W'(HALF);
    iters_o = early_o ? '0 : (ext_eff ? base << 1 : base);
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int XLEN  = 64,
  localparam int DW    = 2 * XLEN,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DW-1:0]     dvd_i,
  input  logic [XLEN-1:0]   dsr_i,
  input  logic [CNT_W-1:0]  iters_i,
  output logic [DW-1:0]     quo_o,
  output logic [XLEN-1:0]   rem_o,
  output logic              idle_o
);
  logic [DW-1:0]    dvd_q;
  logic [XLEN-1:0]  rem_q, dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [XLEN:0]    sh;
  logic [XLEN+1:0]  diff;
  logic             ge;

  always_comb begin
    sh   = {rem_q, dvd_q[DW-1]};
    diff = {1'b0, sh} - {2'b00, dsr_q};
    ge   = ~diff[XLEN+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      dvd_q <= dvd_i;
      rem_q <= '0;
      dsr_q <= dsr_i;
      cnt_q <= iters_i;
    end else if (cnt_q != '0) begin
      dvd_q <= {dvd_q[DW-2:0], ge};
      rem_q <= ge ? diff[XLEN-1:0] : sh[XLEN-1:0];
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo_o  = dvd_q;
  assign rem_o  = rem_q;
  assign idle_o = (cnt_q == '0);

  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R2
  rem_below_dsr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsr_q == '0) || (rem_q < dsr_q));
endmodule

// File: rtl/idiv_post.sv
module idiv_post
  import idiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2,
  localparam int DW   = 2 * XLEN
) (
  input  idiv_op_t        op_i,
  input  logic [DW-1:0]   quo_i,
  input  logic [XLEN-1:0] rem_i,
  input  logic            neg_a_i,
  input  logic            neg_b_i,
  input  logic            early_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);
  logic neg_q, hi_nz, top_b, low_nz, q_ovf;
  logic [XLEN-1:0] q_val, r_val, raw;

  always_comb begin
    neg_q  = neg_a_i ^ neg_b_i;
    hi_nz  = op_i.dw ? |quo_i[DW-1:XLEN] : |quo_i[DW-1:HALF];
    top_b  = op_i.dw ? quo_i[XLEN-1] : quo_i[HALF-1];
    low_nz = op_i.dw ? |quo_i[XLEN-2:0] : |quo_i[HALF-2:0];
    // signed fit: magnitude up to 2^(W-1) only when the quotient is negative
    q_ovf  = op_i.sgn ? (hi_nz | (top_b & (~neg_q | low_nz))) : hi_nz;
    ovf_o  = early_i | (~op_i.rem_op & q_ovf);
    q_val  = neg_q ? '0 - quo_i[XLEN-1:0] : quo_i[XLEN-1:0];
    r_val  = neg_a_i ? '0 - rem_i : rem_i;
    raw    = op_i.rem_op ? r_val : q_val;
    if (ovf_o)          res_o = '0;
    else if (op_i.dw)   res_o = raw;
    else                res_o = {{HALF{1'b0}}, raw[HALF-1:0]};
  end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int DW    = 2 * XLEN,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] ra_i,
  input  logic [XLEN-1:0] rb_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o,
  output logic            ov_o,
  output logic            ov32_o,
  output logic            so_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e state_q;

  idiv_op_t op_in, op_q;
  logic [DW-1:0]    p_dvd, c_quo;
  logic [XLEN-1:0]  p_dsr, c_rem, post_res;
  logic [CNT_W-1:0] p_iters;
  logic p_neg_a, p_neg_b, p_early, neg_a_q, neg_b_q, early_q;
  logic c_idle, post_ovf, accept, fin;

  assign op_in  = idiv_op_t'(op_i);
  assign accept = start_i & (state_q == ST_IDLE);
  assign fin    = (state_q == ST_RUN) & c_idle;

  idiv_prep #(.XLEN(XLEN)) u_prep (
    .op_i(op_in), .ra_i(ra_i), .rb_i(rb_i), .dvd_o(p_dvd), .dsr_o(p_dsr),
    .iters_o(p_iters), .neg_a_o(p_neg_a), .neg_b_o(p_neg_b), .early_o(p_early)
  );

  idiv_core #(.XLEN(XLEN)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .dvd_i(p_dvd),
    .dsr_i(p_dsr), .iters_i(p_iters), .quo_o(c_quo), .rem_o(c_rem), .idle_o(c_idle)
  );

  idiv_post #(.XLEN(XLEN)) u_post (
    .op_i(op_q), .quo_i(c_quo), .rem_i(c_rem), .neg_a_i(neg_a_q),
    .neg_b_i(neg_b_q), .early_i(early_q), .res_o(post_res), .ovf_o(post_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      neg_a_q  <= 1'b0;
      neg_b_q  <= 1'b0;
      early_q  <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
      ov_o     <= 1'b0;
      ov32_o   <= 1'b0;
      so_o     <= 1'b0;
    end else begin
      done_o <= fin;
      if (accept) begin
        state_q <= ST_RUN;
        op_q    <= op_in;
        neg_a_q <= p_neg_a;
        neg_b_q <= p_neg_b;
        early_q <= p_early;
      end else if (fin) begin
        state_q  <= ST_IDLE;
        result_o <= post_res;
        if (!op_q.rem_op) begin
          ov_o   <= post_ovf;
          ov32_o <= post_ovf;
          so_o   <= so_o | post_ovf;
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  so_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o |=> so_o);
  // R8
  ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ov_o && !$past(op_q.rem_op)) |-> result_o == '0);
  // R6
  early_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && p_early) |=> fin);
  // R12
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !fin && start_i) |=> state_q == ST_RUN);
  // R4
  rem_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && op_q.rem_op) |=> $stable(ov_o) && $stable(ov32_o) && $stable(so_o));
endmodule

// File: tb/idiv_unit_bench.sv
module idiv_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] ra = '0, rb = '0;
  logic [63:0] result;
  logic done, ov, ov32, so;
  int total = 0, bad = 0, cyc = 0;
  logic exp_so = 1'b0, exp_ov = 1'b0;
  logic [63:0] last_res = '0;

  always #5 clk = ~clk;

  idiv_unit u_idiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .ra_i(ra), .rb_i(rb),
    .result_o(result), .done_o(done), .ov_o(ov), .ov32_o(ov32), .so_o(so)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] res, output logic ovf, output int lat);
    logic signed [129:0] av, bv, dv, q, r, lim;
    logic dwf, sg, ex, md, early;
    int w;
    dwf = o[0]; sg = o[1]; md = o[3]; ex = o[2] & ~md;
    w = dwf ? 64 : 32;
    if (dwf) begin
      av = sg ? {{66{a[63]}}, a} : {66'b0, a};
      bv = sg ? {{66{b[63]}}, b} : {66'b0, b};
    end else begin
      av = sg ? {{98{a[31]}}, a[31:0]} : {98'b0, a[31:0]};
      bv = sg ? {{98{b[31]}}, b[31:0]} : {98'b0, b[31:0]};
    end
    dv = ex ? (av <<< w) : av;
    lim = 130'sd1;
    lim = lim <<< (w - 1);
    early = (bv == 0) || (sg && (av == -lim) && (bv == -130'sd1));
    if (bv == 0) begin
      q = 0; r = 0; ovf = 1'b1;
    end else begin
      q = dv / bv; r = dv % bv;
      if (sg) ovf = !((q >= -lim) && (q < lim));
      else    ovf = (q >= (lim <<< 1));
      if (md) ovf = early;
    end
    if (ovf)      res = '0;
    else if (md)  res = dwf ? r[63:0] : {32'b0, r[31:0]};
    else          res = dwf ? q[63:0] : {32'b0, q[31:0]};
    lat = early ? 1 : ((dwf ? 64 : 32) * (ex ? 2 : 1) + 1);
  endfunction

  // called at a negedge; start driven at once so back-to-back runs start in the done cycle
  task automatic run_op(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                        input string tag, input logic stray);
    logic [63:0] er; logic eo; int el, n;
    model(o, a, b, er, eo, el);
    op = o; ra = a; rb = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    n = 0;
    // R10 held result, R12 start in done cycle accepted
    chk(done == 1'b0, "R10 done low after start", {63'b0, done}, 64'd0);
    chk(result == last_res, "R12 result held across restart", result, last_res);
    while (!done && n < 300) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (stray && n == 5) begin
        op = ~o; ra = ~a; rb = 64'd3; start = 1'b1;
      end else if (stray && n == 6) start = 1'b0;
    end
    chk(n == el, "R9 latency", 64'(n), 64'(el));
    chk(result == er, tag, result, er);
    if (!o[3]) begin exp_ov = eo; exp_so = exp_so | eo; end
    chk(ov == exp_ov && ov32 == exp_ov, "R11 ov/ov32", {62'b0, ov, ov32}, {62'b0, exp_ov, exp_ov});
    chk(so == exp_so, "R11 so", {63'b0, so}, {63'b0, exp_so});
    last_res = er;
  endtask

  initial begin
    logic [63:0] a, b;
    logic [3:0] o;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R13
    chk(result == 0 && done == 0 && ov == 0 && ov32 == 0 && so == 0, "R13 reset state",
        {result[59:0], done, ov, ov32, so}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(4'b0001, 64'd1000000007, 64'd13, "R2 unsigned dword", 1'b0);
    run_op(4'b0000, 64'hFFFF_FFFF_0000_0064, 64'hABCD_0000_0000_0007, "R1 word low bits", 1'b0);
    run_op(4'b0011, -64'sd7, 64'd2, "R3 signed trunc", 1'b0);
    run_op(4'b0010, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, "R3 signed word", 1'b0);
    run_op(4'b1011, -64'sd7, 64'd2, "R4 signed remainder", 1'b0);
    run_op(4'b1010, 64'd7, 64'h0000_0000_FFFF_FFFE, "R4 word remainder", 1'b0);
    run_op(4'b0101, 64'd1, 64'd3, "R5 dword extended", 1'b0);
    run_op(4'b0100, 64'd5, 64'd7, "R5 word extended", 1'b0);
    run_op(4'b0001, 64'd55, 64'd0, "R6 zero divisor", 1'b0);
    run_op(4'b1001, 64'd55, 64'd0, "R6 zero divisor remainder", 1'b0);
    run_op(4'b0000, 64'd9, 64'hFFFF_FFFF_0000_0000, "R6 word zero divisor", 1'b0);
    run_op(4'b0001, 64'd100, 64'd7, "R11 clear after overflow", 1'b0);
    run_op(4'b0011, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R7 min by minus one", 1'b0);
    run_op(4'b1010, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R7 word remainder", 1'b0);
    run_op(4'b0101, 64'd9, 64'd5, "R8 extended unsigned overflow", 1'b0);
    run_op(4'b0111, 64'd1, 64'd2, "R8 extended signed overflow", 1'b0);
    run_op(4'b0111, -64'sd1, 64'd2, "R8 extended signed negative fits", 1'b0);
    run_op(4'b0001, 64'd999, 64'd10, "R12 stray start ignored", 1'b1);
    for (int i = 0; i < 300; i++) begin
      o = 4'($urandom);
      a = {$urandom, $urandom} >> ($urandom % 64);
      b = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 8 == 0) a = -a;
      if (o[2] && !o[3] && ($urandom % 2 == 1)) b = b | 64'hF000_0000_F000_0000;
      run_op(o, a, b, "R2 random mix", 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule